// File: doc/BRIEF.md
# Interleaved multi-bank vector loader

This block loads a vector register from a memory split into several banks. The bank is chosen by the low-order bits of the word address. Each bank holds an array of words and needs a fixed number of cycles, the latency, for every read. A start pulse gives a base address and an element count. The loader then walks the addresses base, base+1, base+2 and so on. It sends at most one read per clock and rotates through the banks, so the banks work on different elements at the same time. When there are at least as many banks as cycles of latency, one element comes back on every clock once the first read has finished.

A bank that is still working on an earlier read holds up the next request. The loader does not reorder elements, so the whole issue stream waits until that bank is free. Every returned word carries its element index and is written into that slot of a 64-entry vector register. A done pulse marks the arrival of the last element. The register is read through a one-cycle registered read port. A write port fills the banks before a load.

Top module: `vec_bank_loader`

## Requirements
- R1: While reset is high and after it is released, busy and done are 0 until a start is accepted.
- R2: Element i of a load comes from word address (base+i) mod 2^ADDR_W. Its bank is the low log2(NUM_BANKS) address bits and its row is the remaining upper bits. It is written into vector slot i. Driving slot number s on rd_idx returns that slot's word on rd_data after the next rising edge.
- R3: With NUM_BANKS >= BANK_LAT, a load of n > 0 elements started at edge S raises done right after edge S+n+BANK_LAT. Elements are issued on consecutive clocks.
- R4: A bank that received a read at edge t accepts its next read no earlier than edge t+BANK_LAT. Issue then stalls in order. Element i is issued at edge u_i, where u_0 = S+1 and u_i = max(u_{i-1}+1, u_{i-NUM_BANKS}+BANK_LAT). Done rises right after edge u_{n-1}+BANK_LAT.
- R5: At most one bank read is issued per clock, and at most one element is written into the vector register per clock.
- R6: A load of length 0 raises done right after its start edge, never raises busy and writes no slot.
- R7: A requested length above 64 is treated as 64.
- R8: A start pulse that arrives while busy is high is ignored. The running load keeps its base, length, timing and data.
- R9: done is high for exactly one cycle, busy is low whenever done is high, and slots at or above the length of a load keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a load |
| base_addr | input | ADDR_W | Word address of element 0 |
| vec_len | input | $clog2(VLEN+1) | Number of elements to load |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the last element is written |
| mem_wr_en | input | 1 | Write one word into the banked memory |
| mem_wr_addr | input | ADDR_W | Word address of the write |
| mem_wr_data | input | DATA_W | Data of the write |
| rd_idx | input | $clog2(VLEN) | Vector slot to read |
| rd_data | output | DATA_W | Registered contents of the selected slot |

## Verification
The bench builds two copies of the block, both with 8-bit addresses, 16-bit data and a latency of 4. One copy has four banks, which reaches the full rate of one element per clock. The other has two banks, so every second element waits for a bank. In that copy the done edge follows the stall recurrence rather than a plain count, and the bench checks it exactly. The base addresses wrap past the top of memory and start on banks other than bank 0. The lengths include 0, 1, 64 and an oversize value, and a second start is sent while a load is running.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic {LD_IDLE, LD_RUN} ld_state_e;
endpackage

// File: rtl/vload_bank.sv
module vload_bank #(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 6,
  parameter int TAG_W  = 6,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              iss_en,
  input  logic [ROW_W-1:0]  iss_row,
  input  logic [TAG_W-1:0]  iss_tag,
  output logic              free,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DATA_W-1:0] ret_data
);
  localparam int CNT_W = $clog2(LAT + 1);
  localparam int DEPTH = 2 ** ROW_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TAG_W-1:0]  tag_q;

  // a bank in its final cycle may take the next request on the same edge
  assign free      = (cnt_q <= CNT_W'(1));
  assign ret_valid = (cnt_q == CNT_W'(1));
  assign ret_tag   = tag_q;
  assign ret_data  = rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_row] <= wr_data;
    if (iss_en) rdata_q <= store[iss_row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else if (iss_en) begin
      cnt_q <= CNT_W'(LAT);
      tag_q <= iss_tag;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_issue_when_free_R4: assert property (@(posedge clk) disable iff (rst)
    iss_en |-> free);

  assert_busy_after_issue_R4: assert property (@(posedge clk) disable iff (rst)
    iss_en |=> !ret_valid || (LAT == 1));
endmodule

// File: rtl/vload_seq.sv
module vload_seq
  import vload_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 8,
  parameter int VLEN   = 64,
  parameter int LEN_W  = 7,
  parameter int IDX_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        base,
  input  logic [LEN_W-1:0]         len,
  input  logic [NB-1:0]            bank_free,
  input  logic                     ret_any,
  output logic [NB-1:0]            iss_en,
  output logic [ADDR_W-BANK_W-1:0] iss_row,
  output logic [IDX_W-1:0]         iss_tag,
  output logic                     busy,
  output logic                     done
);
  ld_state_e         st_q;
  logic [LEN_W-1:0]  idx_q, rcv_q, len_q;
  logic [ADDR_W-1:0] base_q, addr;
  logic [BANK_W-1:0] bank_sel;
  logic [LEN_W-1:0]  len_eff;
  logic              go;

  assign len_eff  = (len > LEN_W'(VLEN)) ? LEN_W'(VLEN) : len;
  assign addr     = base_q + ADDR_W'(idx_q);
  assign bank_sel = addr[BANK_W-1:0];
  assign iss_row  = addr[ADDR_W-1:BANK_W];
  assign iss_tag  = idx_q[IDX_W-1:0];
  assign go       = (st_q == LD_RUN) && (idx_q < len_q) && bank_free[bank_sel];
  assign busy     = (st_q == LD_RUN);

  always_comb begin
    iss_en = '0;
    if (go) iss_en[bank_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LD_IDLE;
      idx_q  <= '0;
      rcv_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        LD_IDLE: if (start) begin
          base_q <= base;
          len_q  <= len_eff;
          idx_q  <= '0;
          rcv_q  <= '0;
          if (len_eff == '0) done <= 1'b1;
          else               st_q <= LD_RUN;
        end
        default: begin
          if (go) idx_q <= idx_q + LEN_W'(1);
          if (ret_any) begin
            rcv_q <= rcv_q + LEN_W'(1);
            if (rcv_q + LEN_W'(1) == len_q) begin
              st_q <= LD_IDLE;
              done <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(len_q) && $stable(base_q));

  assert_len_capped_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (len_q <= LEN_W'(VLEN)));
endmodule

// File: rtl/vload_vreg.sv
module vload_vreg #(
  parameter int DATA_W = 16,
  parameter int VLEN   = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slots [VLEN];

  always_ff @(posedge clk) begin
    if (we) slots[widx] <= wdata;
    rdata <= slots[ridx];
  end
endmodule

// File: rtl/vec_bank_loader.sv
module vec_bank_loader #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_LAT  = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int VLEN      = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          base_addr,
  input  logic [$clog2(VLEN+1)-1:0]  vec_len,
  output logic                       busy,
  output logic                       done,
  input  logic                       mem_wr_en,
  input  logic [ADDR_W-1:0]          mem_wr_addr,
  input  logic [DATA_W-1:0]          mem_wr_data,
  input  logic [$clog2(VLEN)-1:0]    rd_idx,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int IDX_W  = $clog2(VLEN);
  localparam int LEN_W  = $clog2(VLEN + 1);

  logic [NUM_BANKS-1:0] bank_free, iss_en, ret_valid;
  logic [ROW_W-1:0]     iss_row;
  logic [IDX_W-1:0]     iss_tag;
  logic [IDX_W-1:0]     ret_tag  [NUM_BANKS];
  logic [DATA_W-1:0]    ret_data [NUM_BANKS];
  logic [IDX_W-1:0]     w_idx;
  logic [DATA_W-1:0]    w_data;
  logic                 ret_any;

  vload_seq #(
    .NB(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .VLEN(VLEN), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .base(base_addr), .len(vec_len),
    .bank_free(bank_free), .ret_any(ret_any), .iss_en(iss_en),
    .iss_row(iss_row), .iss_tag(iss_tag), .busy(busy), .done(done)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vload_bank #(
      .DATA_W(DATA_W), .ROW_W(ROW_W), .TAG_W(IDX_W), .LAT(BANK_LAT)
    ) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(mem_wr_en && (mem_wr_addr[BANK_W-1:0] == BANK_W'(b))),
      .wr_row(mem_wr_addr[ADDR_W-1:BANK_W]), .wr_data(mem_wr_data),
      .iss_en(iss_en[b]), .iss_row(iss_row), .iss_tag(iss_tag),
      .free(bank_free[b]), .ret_valid(ret_valid[b]),
      .ret_tag(ret_tag[b]), .ret_data(ret_data[b])
    );
  end

  assign ret_any = |ret_valid;

  always_comb begin
    w_idx  = '0;
    w_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ret_valid[b]) begin
        w_idx  = ret_tag[b];
        w_data = ret_data[b];
      end
    end
  end

  vload_vreg #(.DATA_W(DATA_W), .VLEN(VLEN), .IDX_W(IDX_W)) u_vreg (
    .clk(clk), .we(ret_any), .widx(w_idx), .wdata(w_data),
    .ridx(rd_idx), .rdata(rd_data)
  );

  assert_single_issue_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(iss_en));

  assert_single_return_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ret_valid));

  assert_issue_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (iss_en != '0) |-> busy);
endmodule

// File: tb/vec_bank_loader_tb.sv
module vec_bank_loader_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_v [2];
  logic [7:0]  base_v  [2];
  logic [6:0]  len_v   [2];
  logic        busy_v  [2];
  logic        done_v  [2];
  logic [15:0] rdat_v  [2];
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [5:0]  rd_idx;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] model  [2][64];
  bit          mvalid [2][64];

  always #4 clk = ~clk;

  vec_bank_loader #(.NUM_BANKS(4), .BANK_LAT(4), .ADDR_W(8), .DATA_W(16), .VLEN(64)) u_dut (
    .clk(clk), .rst(rst), .start(start_v[0]), .base_addr(base_v[0]), .vec_len(len_v[0]),
    .busy(busy_v[0]), .done(done_v[0]), .mem_wr_en(wr_en), .mem_wr_addr(wr_addr),
    .mem_wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rdat_v[0]));

  vec_bank_loader #(.NUM_BANKS(2), .BANK_LAT(4), .ADDR_W(8), .DATA_W(16), .VLEN(64)) u_dut_stall (
    .clk(clk), .rst(rst), .start(start_v[1]), .base_addr(base_v[1]), .vec_len(len_v[1]),
    .busy(busy_v[1]), .done(done_v[1]), .mem_wr_en(wr_en), .mem_wr_addr(wr_addr),
    .mem_wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rdat_v[1]));

  // {requirement number, copy select, base, length}
  localparam logic [31:0] TAB [8] = '{
    32'h02_00_00_40, 32'h03_00_05_0A, 32'h02_00_FA_0C, 32'h03_00_03_01,
    32'h04_01_00_10, 32'h04_01_07_05, 32'h04_01_01_40, 32'h07_00_09_64
  };

  function automatic logic [15:0] pat(int a);
    return 16'((a * 613 + 4660) & 16'hFFFF);
  endfunction

  // R3 and R4: edges after the start edge until done is visible
  function automatic int exp_edges(int sel, int n);
    int nb = (sel != 0) ? 2 : 4;
    int t [64];
    if (n == 0) return 0;
    for (int i = 0; i < n; i++) begin
      t[i] = (i == 0) ? 1 : t[i-1] + 1;
      if (i >= nb && t[i-nb] + 4 > t[i]) t[i] = t[i-nb] + 4;
    end
    return t[n-1] + 4;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_vreg(int sel, string req);
    for (int i = 0; i < 64; i++) begin
      if (mvalid[sel][i]) begin
        rd_idx = 6'(i);
        @(negedge clk);
        check(rdat_v[sel] === model[sel][i], req, $sformatf("slot %0d copy %0d", i, sel),
              int'(rdat_v[sel]), int'(model[sel][i]));
      end
    end
  endtask

  task automatic run(int sel, int base, int len, bit poke, string req);
    int n_eff = (len > 64) ? 64 : len;
    int exp = exp_edges(sel, n_eff);
    int k = 0;
    start_v[sel] = 1'b1;
    base_v[sel] = 8'(base);
    len_v[sel] = 7'(len);
    @(negedge clk);
    start_v[sel] = 1'b0;
    check(busy_v[sel] == (n_eff > 0), req, "busy after start", int'(busy_v[sel]), int'(n_eff > 0));
    while (!done_v[sel] && k < 400) begin
      if (poke && k == 2) begin  // R8: second start while running
        start_v[sel] = 1'b1;
        base_v[sel] = 8'd100;
        len_v[sel] = 7'd5;
      end
      @(negedge clk);
      start_v[sel] = 1'b0;
      k++;
    end
    check(k == exp, req, "done edge", k, exp);
    check(busy_v[sel] == 1'b0, "R9", "busy at done", int'(busy_v[sel]), 0);
    @(negedge clk);
    check(done_v[sel] == 1'b0, "R9", "done pulse width", int'(done_v[sel]), 0);
    for (int i = 0; i < n_eff; i++) begin
      model[sel][i] = pat((base + i) & 255);
      mvalid[sel][i] = 1'b1;
    end
    check_vreg(sel, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_idx = '0;
    for (int s = 0; s < 2; s++) begin
      start_v[s] = 1'b0; base_v[s] = '0; len_v[s] = '0;
      for (int i = 0; i < 64; i++) mvalid[s][i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      check(busy_v[s] == 1'b0 && done_v[s] == 1'b0, "R1", "outputs in reset",
            int'({busy_v[s], done_v[s]}), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(busy_v[0] == 1'b0 && done_v[0] == 1'b0, "R1", "outputs after reset",
          int'({busy_v[0], done_v[0]}), 0);

    for (int a = 0; a < 256; a++) begin
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = pat(a);
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R2 R3 R4 R7 table walk
    for (int e = 0; e < 8; e++) begin
      run(int'(TAB[e][23:16]), int'(TAB[e][15:8]), int'(TAB[e][7:0]), 1'b0,
          $sformatf("R%0d", int'(TAB[e][31:24])));
    end

    // R6: zero length, slots unchanged on both copies
    run(0, 40, 0, 1'b0, "R6");
    run(1, 40, 0, 1'b0, "R6");
    // R8: start during a load is ignored
    run(0, 0, 20, 1'b1, "R8");
    // R5 R9: short loads after longer ones leave upper slots untouched
    run(1, 200, 3, 1'b0, "R5");
    run(0, 255, 2, 1'b0, "R9");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule